// File: doc/BRIEF.md
# Server Reply Bytecode Loader

This block takes a server reply as a byte stream and splits it into operations. Each operation is a code byte, then a 24-bit big-endian argument length, then that many argument (body) bytes. The reply end marker 0xFF carries no length. Two operations are acted upon. A sources update writes value bytes into a 64-byte sources RAM through a write port. A bytecode frame is checked against its framing rules while its program bytes stream into program memory through a second write port. Every other code has its body consumed and dropped.

A frame body is laid out as: the five ASCII bytes "amber" (0x61 0x6D 0x62 0x65 0x72) at body offsets 0..4, a 4-byte big-endian identifier at 5..8, a transition byte at 9 (0x01 means immediate), a 4-byte big-endian program size at 10..13, and the program bytes from offset 14. Music count, offsets and data follow the program and are skipped. The block does not decode them: it finds the checksum byte from the operation length, as the fifth byte from the end. The last four bytes are "mind" (0x6D 0x69 0x6E 0x64). Frame-ok or frame-error reports the verdict. On a good frame, the identifier and the immediate flag are published.

The input follows valid/ready rules. A byte moves on each clock edge where `in_valid` and `in_ready` are both high. Every byte is handled in one cycle, so `in_ready` is low only while `rst` is high. The block never applies back-pressure. The source may hold `in_valid` low for any number of cycles between bytes. The write ports have no ready signal. Each write is a one-cycle strobe, registered on the edge that accepts the byte.

Top module: `bytecode_reply_parser`

## Requirements
- R1: An operation is a code byte followed by a 24-bit big-endian length and that many body bytes. The body of any code other than 0x04 and 0x05 produces no write and leaves the frame outputs unchanged. A zero length makes the next byte a code.
- R2: Code 0xFF ends a reply, has no length field, and the byte that follows it is read as a code.
- R3: In a sources update (code 0x04), body bytes 0..3 are an identifier and cause no write. Body byte 4+j is written to sources address j, with `src_we` high in the cycle after its acceptance. This holds for j from 0 to 62; later bytes are ignored.
- R4: Program byte i of a frame (code 0x05) is written to program address 17+i, with `prog_we` high in the cycle after acceptance. Writes stop once an error has been seen in the frame.
- R5: The 8-bit sum of all frame body bytes, including the checksum byte, must be 0xFF. Otherwise `frame_err` is set after the last body byte.
- R6: Body bytes 0..4 must be "amber" and the last four body bytes must be "mind". A mismatch sets `frame_err` in the cycle after the offending byte.
- R7: A program size above 65519 sets `frame_err`, and none of that frame's program bytes is written.
- R8: In the cycle after the last body byte of a frame, exactly one of `frame_ok` and `frame_err` is high, and the two are never high together. Both clear on the first body byte of the next frame.
- R9: `frame_id` (body bytes 5..8) and `frame_now` (body byte 9 equal to 0x01) update only together with `frame_ok` rising. Otherwise they hold.
- R10: The checksum is the fifth body byte from the end. A frame whose program has not ended before that byte is in error.
- R11: `in_ready` is high whenever `rst` is low. No write happens in a cycle that follows a cycle with `in_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Reply byte |
| prog_we | output | 1 | Program memory write strobe |
| prog_addr | output | 16 | Program memory address |
| prog_data | output | 8 | Program memory data |
| src_we | output | 1 | Sources RAM write strobe |
| src_addr | output | 6 | Sources RAM address |
| src_data | output | 8 | Sources RAM data |
| frame_id | output | 32 | Identifier of the last good frame |
| frame_now | output | 1 | Last good frame asked for an immediate transition |
| frame_ok | output | 1 | Last frame passed all checks |
| frame_err | output | 1 | Current or last frame failed a check |

## Verification
On every cycle, the assertions check the following properties:
- `frame_ok` and `frame_err` are never high together.
- Every write strobe follows an accepted byte.
- Program writes start at 17 or above and climb by one when back to back.
- Sources addresses stay below 63.
- The published identifier moves only with `frame_ok`.

Some behaviours only the bench scenarios can show:
- Whether each byte lands at the right address with the right value.
- Whether the verdict matches each class of corrupted frame.
- How unknown codes, zero lengths and the end marker are treated.
- That an overlong sources update is cut at 63 values.

// File: rtl/bcp_pkg.sv
package bcp_pkg;
  localparam logic [7:0] OPC_SOURCES = 8'h04;
  localparam logic [7:0] OPC_FRAME   = 8'h05;
  localparam logic [7:0] OPC_END     = 8'hFF;

  typedef enum logic [1:0] {OS_CODE, OS_LEN, OS_BODY} op_st_e;
  typedef enum logic [2:0] {FP_HEAD, FP_ID, FP_FLAG, FP_SIZE, FP_PROG, FP_SKIP} frm_ph_e;

  // leading frame word, one byte per index
  function automatic logic [7:0] head_byte(input logic [2:0] i);
    case (i)
      3'd0:    return 8'h61;
      3'd1:    return 8'h6D;
      3'd2:    return 8'h62;
      3'd3:    return 8'h65;
      default: return 8'h72;
    endcase
  endfunction

  // trailing frame word, one byte per index
  function automatic logic [7:0] tail_byte(input logic [1:0] i);
    case (i)
      2'd0:    return 8'h6D;
      2'd1:    return 8'h69;
      2'd2:    return 8'h6E;
      default: return 8'h64;
    endcase
  endfunction
endpackage

// File: rtl/bcp_op_split.sv
module bcp_op_split
  import bcp_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [7:0]       data,
  output logic             body_vld,
  output logic [7:0]       body_code,
  output logic             body_first,
  output logic             body_last,
  output logic [LEN_W-1:0] body_rem
);
  localparam int LEN_BYTES = LEN_W / 8;
  localparam int LB_W      = $clog2(LEN_BYTES);

  op_st_e           st_q;
  logic [7:0]       code_q;
  logic [LB_W-1:0]  lb_q;
  logic [LEN_W-9:0] len_q;
  logic [LEN_W-1:0] cnt_q;
  logic             first_q;
  logic [LEN_W-1:0] len_full;

  assign len_full = {len_q, data};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= OS_CODE;
      code_q  <= '0;
      lb_q    <= '0;
      len_q   <= '0;
      cnt_q   <= '0;
      first_q <= 1'b0;
    end else if (acc) begin
      case (st_q)
        OS_CODE: begin
          code_q <= data;
          lb_q   <= '0;
          if (data != OPC_END) st_q <= OS_LEN;
        end
        OS_LEN: begin
          len_q <= {len_q[LEN_W-17:0], data};
          lb_q  <= lb_q + LB_W'(1);
          if (lb_q == LB_W'(LEN_BYTES - 1)) begin
            cnt_q   <= len_full;
            first_q <= 1'b1;
            st_q    <= (len_full == '0) ? OS_CODE : OS_BODY;
          end
        end
        OS_BODY: begin
          cnt_q   <= cnt_q - LEN_W'(1);
          first_q <= 1'b0;
          if (cnt_q == LEN_W'(1)) st_q <= OS_CODE;
        end
        default: st_q <= OS_CODE;
      endcase
    end
  end

  assign body_vld   = acc && (st_q == OS_BODY);
  assign body_code  = code_q;
  assign body_first = first_q;
  assign body_last  = (cnt_q == LEN_W'(1));
  assign body_rem   = cnt_q - LEN_W'(1);
endmodule

// File: rtl/bcp_src_writer.sv
module bcp_src_writer #(
  parameter int SRC_DEPTH = 64,
  parameter int ID_BYTES  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         vld,
  input  logic                         first,
  input  logic [7:0]                   data,
  output logic                         src_we,
  output logic [$clog2(SRC_DEPTH)-1:0] src_addr,
  output logic [7:0]                   src_data
);
  localparam int SRC_AW = $clog2(SRC_DEPTH);
  localparam int LIMIT  = ID_BYTES + SRC_DEPTH - 1;
  localparam int IDX_W  = $clog2(LIMIT + 1);

  logic [IDX_W-1:0] idx_q, cur;
  logic             wr;

  always_comb begin
    cur = first ? '0 : idx_q;
    wr  = (cur >= IDX_W'(ID_BYTES)) && (cur < IDX_W'(LIMIT));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      src_we   <= 1'b0;
      src_addr <= '0;
      src_data <= '0;
    end else begin
      src_we   <= vld && wr;
      src_addr <= SRC_AW'(cur - IDX_W'(ID_BYTES));
      src_data <= data;
      if (vld) idx_q <= (cur == IDX_W'(LIMIT)) ? cur : cur + IDX_W'(1);
    end
  end
endmodule

// File: rtl/bcp_frame_chk.sv
module bcp_frame_chk
  import bcp_pkg::*;
#(
  parameter int LEN_W     = 24,
  parameter int ADDR_W    = 16,
  parameter int PROG_BASE = 17,
  parameter int PROG_MAX  = 65519
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              vld,
  input  logic              first,
  input  logic              last,
  input  logic [LEN_W-1:0]  rem,
  input  logic [7:0]        data,
  output logic              prog_we,
  output logic [ADDR_W-1:0] prog_addr,
  output logic [7:0]        prog_data,
  output logic [31:0]       frame_id,
  output logic              frame_now,
  output logic              frame_ok,
  output logic              frame_err
);
  localparam int SZ_W = 32;

  frm_ph_e          ph_q, ph_c, ph_n;
  logic [2:0]       k_q, k_c, k_n;
  logic [7:0]       sum_q, sum_n;
  logic             err_q, err_c, err_n, bad, tail, wr;
  logic [31:0]      id_q, id_n;
  logic             flag_q, flag_n;
  logic [SZ_W-1:0]  size_q, size_n;
  logic [ADDR_W-1:0] pc_q, pc_n;

  always_comb begin
    ph_c   = first ? FP_HEAD : ph_q;
    k_c    = first ? 3'd0 : k_q;
    err_c  = first ? 1'b0 : err_q;
    sum_n  = (first ? 8'h00 : sum_q) + data;
    tail   = (rem <= LEN_W'(4));
    ph_n   = ph_c;
    k_n    = k_c + 3'd1;
    id_n   = id_q;
    flag_n = flag_q;
    size_n = size_q;
    pc_n   = pc_q;
    bad    = 1'b0;
    wr     = 1'b0;
    if (tail) begin
      // checksum byte sits at rem==4, trailing word follows
      bad = (ph_c != FP_SKIP) ||
            ((rem != LEN_W'(4)) && (data != tail_byte(~rem[1:0])));
    end else begin
      case (ph_c)
        FP_HEAD: begin
          bad = (data != head_byte(k_c));
          if (k_c == 3'd4) begin ph_n = FP_ID; k_n = 3'd0; end
        end
        FP_ID: begin
          id_n = {id_q[23:0], data};
          if (k_c == 3'd3) begin ph_n = FP_FLAG; k_n = 3'd0; end
        end
        FP_FLAG: begin
          flag_n = (data == 8'h01);
          ph_n   = FP_SIZE;
          k_n    = 3'd0;
        end
        FP_SIZE: begin
          size_n = {size_q[SZ_W-9:0], data};
          if (k_c == 3'd3) begin
            k_n  = 3'd0;
            pc_n = '0;
            bad  = (size_n > SZ_W'(PROG_MAX));
            ph_n = (size_n == '0) ? FP_SKIP : FP_PROG;
          end
        end
        FP_PROG: begin
          wr   = 1'b1;
          pc_n = pc_q + ADDR_W'(1);
          if (SZ_W'(pc_q) + SZ_W'(1) == size_q) ph_n = FP_SKIP;
        end
        default: ;
      endcase
    end
    if (last && (sum_n != 8'hFF)) bad = 1'b1;
    err_n = err_c | bad;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q      <= FP_HEAD;
      k_q       <= '0;
      sum_q     <= '0;
      err_q     <= 1'b0;
      id_q      <= '0;
      flag_q    <= 1'b0;
      size_q    <= '0;
      pc_q      <= '0;
      prog_we   <= 1'b0;
      prog_addr <= '0;
      prog_data <= '0;
      frame_id  <= '0;
      frame_now <= 1'b0;
      frame_ok  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      prog_we   <= vld && wr && !err_n;
      prog_addr <= ADDR_W'(PROG_BASE) + pc_q;
      prog_data <= data;
      if (vld) begin
        ph_q   <= ph_n;
        k_q    <= k_n;
        sum_q  <= sum_n;
        err_q  <= err_n;
        id_q   <= id_n;
        flag_q <= flag_n;
        size_q <= size_n;
        pc_q   <= pc_n;
        frame_err <= err_n;
        if (last) begin
          frame_ok <= !err_n;
          if (!err_n) begin
            frame_id  <= id_q;
            frame_now <= flag_q;
          end
        end else begin
          frame_ok <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/bytecode_reply_parser.sv
module bytecode_reply_parser
  import bcp_pkg::*;
#(
  parameter int LEN_W     = 24,
  parameter int ADDR_W    = 16,
  parameter int SRC_DEPTH = 64,
  parameter int PROG_BASE = 17,
  parameter int PROG_MAX  = 65519
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [7:0]                   in_data,
  output logic                         prog_we,
  output logic [ADDR_W-1:0]            prog_addr,
  output logic [7:0]                   prog_data,
  output logic                         src_we,
  output logic [$clog2(SRC_DEPTH)-1:0] src_addr,
  output logic [7:0]                   src_data,
  output logic [31:0]                  frame_id,
  output logic                         frame_now,
  output logic                         frame_ok,
  output logic                         frame_err
);
  logic             acc, body_vld, body_first, body_last;
  logic [7:0]       body_code;
  logic [LEN_W-1:0] body_rem;

  assign in_ready = !rst;
  assign acc      = in_valid && in_ready;

  bcp_op_split #(.LEN_W(LEN_W)) u_split (
    .clk(clk), .rst(rst), .acc(acc), .data(in_data),
    .body_vld(body_vld), .body_code(body_code), .body_first(body_first),
    .body_last(body_last), .body_rem(body_rem)
  );

  bcp_src_writer #(.SRC_DEPTH(SRC_DEPTH), .ID_BYTES(4)) u_src (
    .clk(clk), .rst(rst),
    .vld(body_vld && (body_code == OPC_SOURCES)),
    .first(body_first), .data(in_data),
    .src_we(src_we), .src_addr(src_addr), .src_data(src_data)
  );

  bcp_frame_chk #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .PROG_BASE(PROG_BASE), .PROG_MAX(PROG_MAX)
  ) u_frame (
    .clk(clk), .rst(rst),
    .vld(body_vld && (body_code == OPC_FRAME)),
    .first(body_first), .last(body_last), .rem(body_rem), .data(in_data),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .frame_id(frame_id), .frame_now(frame_now),
    .frame_ok(frame_ok), .frame_err(frame_err)
  );
endmodule

// File: rtl/bcp_chk.sv
module bcp_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        prog_we,
  input logic [15:0] prog_addr,
  input logic        src_we,
  input logic [5:0]  src_addr,
  input logic [31:0] frame_id,
  input logic        frame_ok,
  input logic        frame_err
);
  // R8
  verdict_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(frame_ok && frame_err));
  // R4
  prog_base_chk: assert property (@(posedge clk) disable iff (rst)
    prog_we |-> (prog_addr >= 16'd17));
  // R4
  prog_accept_chk: assert property (@(posedge clk) disable iff (rst)
    prog_we |-> $past(in_valid && in_ready));
  // R4
  prog_seq_chk: assert property (@(posedge clk) disable iff (rst)
    (prog_we && $past(prog_we)) |-> (prog_addr == $past(prog_addr) + 16'd1));
  // R3
  src_range_chk: assert property (@(posedge clk) disable iff (rst)
    src_we |-> (src_addr < 6'd63));
  // R11
  src_accept_chk: assert property (@(posedge clk) disable iff (rst)
    src_we |-> $past(in_valid && in_ready));
  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (frame_id != $past(frame_id)) |-> frame_ok);
endmodule

bind bytecode_reply_parser bcp_chk u_chk (.*);

// File: tb/bytecode_reply_parser_bench.sv
`timescale 1ns/1ps
module bytecode_reply_parser_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = '0;
  logic        prog_we, src_we, frame_now, frame_ok, frame_err;
  logic [15:0] prog_addr;
  logic [7:0]  prog_data, src_data;
  logic [5:0]  src_addr;
  logic [31:0] frame_id;

  int vecs = 0;
  int fails = 0;
  logic [7:0]  fb [0:1023];
  logic [31:0] m_id = '0;
  bit          m_imm = 1'b0;

  always #4 clk = ~clk;

  bytecode_reply_parser u_bytecode_reply_parser (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // present one byte, optionally after an idle cycle; returns at the negedge after acceptance
  task automatic put(input logic [7:0] b);
    if ($urandom % 4 == 0) begin
      in_valid = 1'b0;
      @(posedge clk); @(negedge clk);
      chk("R11 idle no prog write", prog_we, 0);
      chk("R11 idle no src write", src_we, 0);
    end
    in_data = b; in_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic put_len(input int l);
    put(8'(l >> 16)); put(8'(l >> 8)); put(8'(l));
  endtask

  // kind: 0 good, 1 head magic, 2 tail magic, 3 checksum, 4 truncated, 5 oversize
  task automatic send_frame(input int kind, input logic [31:0] id, input bit imm,
                            input int size, input int nmus, input int mlen);
    int n, l, s;
    int decl;
    string tag;
    bit ew;
    case (kind)
      0: tag = "R8 good frame";
      1: tag = "R6 head word";
      2: tag = "R6 tail word";
      3: tag = "R5 checksum";
      4: tag = "R10 truncated";
      default: tag = "R7 oversize";
    endcase
    fb[0] = 8'h61; fb[1] = 8'h6D; fb[2] = 8'h62; fb[3] = 8'h65; fb[4] = 8'h72;
    if (kind == 1) fb[2] = 8'h42;
    for (int i = 0; i < 4; i++) fb[5+i] = 8'(id >> (24 - 8*i));
    fb[9] = imm ? 8'h01 : 8'h00;
    decl = (kind == 5) ? 65520 : ((kind == 4) ? size + 7 : size);
    for (int i = 0; i < 4; i++) fb[10+i] = 8'(decl >> (24 - 8*i));
    n = 14;
    for (int p = 0; p < size; p++) begin fb[n] = 8'($urandom); n++; end
    if (kind != 4) begin
      for (int i = 0; i < 4; i++) begin fb[n] = 8'(nmus >> (24 - 8*i)); n++; end
      for (int i = 0; i < 4*nmus + mlen; i++) begin fb[n] = 8'($urandom); n++; end
    end
    s = 0;
    for (int i = 0; i < n; i++) s += fb[i];
    s += 8'h6D + 8'h69 + 8'h6E + 8'h64;
    fb[n] = 8'(255 - s + ((kind == 3) ? 1 : 0));
    fb[n+1] = 8'h6D; fb[n+2] = 8'h69; fb[n+3] = 8'h6E; fb[n+4] = 8'h64;
    if (kind == 2) begin
      fb[n+4] = 8'h44;
      fb[n] = fb[n] + 8'h20;
    end
    l = n + 5;
    put(8'h05); put_len(l);
    for (int i = 0; i < l; i++) begin
      put(fb[i]);
      ew = (kind != 1) && (kind != 5) && (i >= 14) && (i < 14 + size);
      chk({tag, " R4 prog_we"}, prog_we, ew);
      if (ew) begin
        chk("R4 prog_addr", prog_addr, 32'(17 + i - 14));
        chk("R4 prog_data", prog_data, fb[i]);
      end
      chk("R3 no src write in frame", src_we, 0);
      if (kind == 1 && i == 2) chk("R6 early head error", frame_err, 1);
    end
    chk({tag, " R8 frame_ok"}, frame_ok, kind == 0);
    chk({tag, " R8 frame_err"}, frame_err, kind != 0);
    if (kind == 0) begin m_id = id; m_imm = imm; end
    chk("R9 frame_id", frame_id, m_id);
    chk("R9 frame_now", frame_now, m_imm);
  endtask

  task automatic send_src(input int nv);
    logic [7:0] v;
    bit ew;
    put(8'h04); put_len(4 + nv);
    for (int i = 0; i < 4; i++) begin
      put(8'($urandom));
      chk("R3 id bytes no write", src_we, 0);
    end
    for (int j = 0; j < nv; j++) begin
      v = 8'($urandom);
      put(v);
      ew = (j < 63);
      chk("R3 src_we", src_we, ew);
      if (ew) begin
        chk("R3 src_addr", src_addr, j);
        chk("R3 src_data", src_data, v);
      end
      chk("R4 no prog write in sources", prog_we, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd2718));
    @(negedge clk);
    chk("R11 ready low in reset", in_ready, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11 ready after reset", in_ready, 1);
    chk("R8 reset frame_ok", frame_ok, 0);
    chk("R8 reset frame_err", frame_err, 0);
    chk("R9 reset frame_id", frame_id, 0);
    chk("R4 reset prog_we", prog_we, 0);

    // directed corner cases
    send_frame(0, 32'hA1B2C3D4, 1'b1, 0, 0, 0);
    send_frame(0, 32'h01020304, 1'b0, 5, 2, 7);
    send_frame(1, 32'hDEAD0001, 1'b1, 4, 0, 0);
    send_frame(2, 32'hDEAD0002, 1'b1, 6, 1, 3);
    send_frame(3, 32'hDEAD0003, 1'b0, 3, 0, 2);
    send_frame(4, 32'hDEAD0004, 1'b1, 3, 0, 0);
    send_frame(5, 32'hDEAD0005, 1'b1, 8, 0, 0);
    send_frame(0, 32'h55AA55AA, 1'b1, 1, 0, 0);

    send_src(10);
    send_src(70);

    // R1 unknown code with a frame-looking body, then a zero-length op
    put(8'h09); put_len(6);
    for (int i = 0; i < 6; i++) begin
      put((i == 0) ? 8'h05 : 8'h61);
      chk("R1 unknown no prog write", prog_we, 0);
      chk("R1 unknown no src write", src_we, 0);
    end
    chk("R1 unknown keeps frame_ok", frame_ok, 1);
    chk("R1 unknown keeps frame_id", frame_id, m_id);
    put(8'h30); put_len(0);
    send_src(2);

    // R2 end marker then immediately new operations
    put(8'hFF);
    chk("R2 end marker no write", src_we, 0);
    send_src(3);
    put(8'hFF);
    send_frame(0, 32'h0BADF00D, 1'b0, 7, 1, 1);

    // constrained random mix
    for (int t = 0; t < 30; t++) begin
      int kind;
      kind = ($urandom % 3 == 0) ? int'($urandom % 6) : 0;
      if ($urandom % 5 == 0) send_src(1 + int'($urandom % 20));
      if ($urandom % 6 == 0) put(8'hFF);
      send_frame(kind, $urandom, 1'($urandom), int'($urandom % 41),
                 int'($urandom % 4), int'($urandom % 16));
    end

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule